// File: doc/BRIEF.md
# Keyed Mode-Register Write Guard

This block is a single 32-bit memory-mapped control word that decides whether the direction-mode registers of one or more GPIO banks may be changed. Software opens the guard by writing a 16-bit unlock code into the low half of the word and shuts it again by writing zero there. Any other code leaves the guard as it was. While the guard is open, a per-bank write-enable output is high, and the mode registers of those banks accept writes. While it is shut, they ignore them.

Before changing a direction mode, software reads the word. If the top bit is already set, another agent holds the guard and the caller backs off. The word sits in an 8-byte window on a simple register bus with address, write data, a write strobe, a read strobe and read data. The unlock code is never returned on reads, so it cannot be learned by polling the register.

Top module: `keyed_wlock`

## Requirements
- R1: After reset the guard is shut, every `mode_wr_en` bit is 0, and a read of the lock word returns 0.
- R2: A write to the lock word (byte offset 0 of the window at `BASE_ADDR`, default 0x088) whose bits [15:0] equal 0xD42F opens the guard, whatever bits [31:16] hold. Writing that code while the guard is already open keeps it open.
- R3: A write to the lock word whose bits [15:0] equal 0x0000 shuts the guard. Address bits [1:0] are ignored, so byte addresses 0x088 to 0x08B all select the lock word.
- R4: A write to the lock word with any other value in bits [15:0] leaves the guard unchanged, whether it is open or shut.
- R5: A read of the lock word returns the guard state in bit 31 (1 = open), and 0 in bits [30:0], so the unlock code is never exposed.
- R6: Each bit of `mode_wr_en` is a registered copy of the guard state. It changes one clock after the state does, which is two rising edges after the write strobe is sampled.
- R7: Writes to the second word of the window (offset 4) or to any address outside the window have no effect on the guard, and reads of those addresses return 0.
- R8: When a read and a write to the lock word are sampled on the same edge, the read returns the guard state from before that write.
- R9: `bus_rdata` is loaded on the rising edge that samples `bus_rd`, is valid from then on, and holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | DATA_W (32) | Registered read data |
| mode_wr_en | output | NUM_BANKS (3) | Write enables for the banks' mode registers |

## Verification
The two functions that can fall on the same edge are the readback of the status bit and the state change caused by a write. The bench drives a read strobe and a write strobe together, first with the unlock code while the guard is shut and then with zero while it is open. In both cases it expects the read to report the state from before the write, and a following plain read to report the new state. In the same writes, the enable outputs are checked both one and two cycles after the strobe, to confirm the extra register stage.

// File: rtl/wlk_pkg.sv
package wlk_pkg;

   // Command decoded from a write to the lock word
   typedef enum logic [1:0] {
      CMD_NONE  = 2'd0,
      CMD_OPEN  = 2'd1,
      CMD_CLOSE = 2'd2
   } wlk_cmd_e;

endpackage

// File: rtl/wlk_decode.sv
module wlk_decode
   import wlk_pkg::*;
#(
   parameter int                ADDR_W    = 12,
   parameter int                KEY_W     = 16,
   parameter int                WIN_BYTES = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h088,
   parameter logic [KEY_W-1:0]  OPEN_KEY  = 16'hD42F,
   parameter logic [KEY_W-1:0]  CLOSE_KEY = 16'h0000
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [KEY_W-1:0]  key,
   input  logic              wr,
   input  logic              rd,
   output logic              rd_lock,
   output wlk_cmd_e          cmd
);

   localparam int WIN_LSB = $clog2(WIN_BYTES);

   logic in_window;
   logic lock_slot;
   logic unused_low;

   assign in_window  = (addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]);
   assign lock_slot  = (addr[WIN_LSB-1:2] == '0);
   assign unused_low = ^addr[1:0];
   assign rd_lock    = rd && in_window && lock_slot;

   always_comb begin
      cmd = CMD_NONE;
      if (wr && in_window && lock_slot) begin
         if (key == OPEN_KEY)
            cmd = CMD_OPEN;
         else if (key == CLOSE_KEY)
            cmd = CMD_CLOSE;
      end
   end

endmodule

// File: rtl/wlk_state.sv
module wlk_state
   import wlk_pkg::*;
#(
   parameter int NUM_BANKS = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  wlk_cmd_e             cmd,
   output logic                 lock_q,
   output logic [NUM_BANKS-1:0] bank_we
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lock_q <= 1'b0;
      else if (cmd == CMD_OPEN)
         lock_q <= 1'b1;
      else if (cmd == CMD_CLOSE)
         lock_q <= 1'b0;
   end

   // One flop per bank keeps fan-out local to each bank
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bank_we[b] <= 1'b0;
         else
            bank_we[b] <= lock_q;
      end
   end

endmodule

// File: rtl/wlk_readback.sv
module wlk_readback #(
   parameter int DATA_W     = 32,
   parameter int STATUS_BIT = DATA_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  logic              rd_lock,
   input  logic              lock_q,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] status_word;

   always_comb begin
      status_word             = '0;
      status_word[STATUS_BIT] = lock_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd)
         rdata <= rd_lock ? status_word : '0;
   end

endmodule

// File: rtl/keyed_wlock.sv
module keyed_wlock
   import wlk_pkg::*;
#(
   parameter int                ADDR_W    = 12,
   parameter int                DATA_W    = 32,
   parameter int                KEY_W     = 16,
   parameter int                WIN_BYTES = 8,
   parameter int                NUM_BANKS = 3,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h088,
   parameter logic [KEY_W-1:0]  OPEN_KEY  = 16'hD42F,
   parameter logic [KEY_W-1:0]  CLOSE_KEY = 16'h0000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic [NUM_BANKS-1:0] mode_wr_en
);

   localparam int WIN_LSB    = $clog2(WIN_BYTES);
   localparam int STATUS_BIT = DATA_W - 1;

   // Elaboration-time parameter checks
   if (KEY_W >= STATUS_BIT) begin : g_bad_key_w
      $error("keyed_wlock: key field overlaps the status bit");
   end
   if (WIN_BYTES < 8 || (1 << WIN_LSB) != WIN_BYTES) begin : g_bad_win
      $error("keyed_wlock: window must be a power of two of at least 8 bytes");
   end
   if (BASE_ADDR[WIN_LSB-1:0] != '0) begin : g_bad_base
      $error("keyed_wlock: base address not aligned to the window");
   end
   if (OPEN_KEY == CLOSE_KEY) begin : g_bad_keys
      $error("keyed_wlock: open and close codes must differ");
   end
   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("keyed_wlock: at least one bank is required");
   end

   wlk_cmd_e cmd;
   logic     rd_lock;
   logic     lock_q;
   logic     unused_wdata;

   assign unused_wdata = ^bus_wdata[DATA_W-1:KEY_W];

   wlk_decode #(
      .ADDR_W    (ADDR_W),
      .KEY_W     (KEY_W),
      .WIN_BYTES (WIN_BYTES),
      .BASE_ADDR (BASE_ADDR),
      .OPEN_KEY  (OPEN_KEY),
      .CLOSE_KEY (CLOSE_KEY)
   ) u_decode (
      .addr    (bus_addr),
      .key     (bus_wdata[KEY_W-1:0]),
      .wr      (bus_wr),
      .rd      (bus_rd),
      .rd_lock (rd_lock),
      .cmd     (cmd)
   );

   wlk_state #(
      .NUM_BANKS (NUM_BANKS)
   ) u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (cmd),
      .lock_q  (lock_q),
      .bank_we (mode_wr_en)
   );

   wlk_readback #(
      .DATA_W     (DATA_W),
      .STATUS_BIT (STATUS_BIT)
   ) u_readback (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd      (bus_rd),
      .rd_lock (rd_lock),
      .lock_q  (lock_q),
      .rdata   (bus_rdata)
   );

endmodule

// File: rtl/wlk_checker.sv
module wlk_checker #(
   parameter int                ADDR_W    = 12,
   parameter int                DATA_W    = 32,
   parameter int                KEY_W     = 16,
   parameter int                WIN_BYTES = 8,
   parameter int                NUM_BANKS = 3,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h088,
   parameter logic [KEY_W-1:0]  OPEN_KEY  = 16'hD42F,
   parameter logic [KEY_W-1:0]  CLOSE_KEY = 16'h0000
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic [DATA_W-1:0]    bus_wdata,
   input logic                 bus_wr,
   input logic                 bus_rd,
   input logic [DATA_W-1:0]    bus_rdata,
   input logic [NUM_BANKS-1:0] mode_wr_en,
   input logic                 lock_q
);

   localparam int WIN_LSB = $clog2(WIN_BYTES);

   logic hit;
   logic unused_chk;

   assign hit = (bus_addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB])
             && (bus_addr[WIN_LSB-1:2] == '0);
   assign unused_chk = ^{bus_addr[1:0], bus_wdata[DATA_W-1:KEY_W]};

   // R2: unlock code opens the guard
   p_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit && bus_wdata[KEY_W-1:0] == OPEN_KEY) |=> lock_q);

   // R3: zero code shuts the guard
   p_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit && bus_wdata[KEY_W-1:0] == CLOSE_KEY) |=> !lock_q);

   // R4 and R7: anything else leaves the state alone
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && hit && (bus_wdata[KEY_W-1:0] == OPEN_KEY ||
                          bus_wdata[KEY_W-1:0] == CLOSE_KEY)) |=> $stable(lock_q));

   // R5: nothing but the status bit is ever visible
   p_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DATA_W-2:0] == '0);

   // R6: bank enables follow the state one cycle later
   p_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (mode_wr_en == {NUM_BANKS{$past(lock_q)}}));

   // R8: a read reports the state it saw on its own edge
   p_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && hit) |=> (bus_rdata[DATA_W-1] == $past(lock_q)));

   // R9: read data holds while no read is issued
   p_hold_rdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

endmodule

bind keyed_wlock wlk_checker #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .KEY_W     (KEY_W),
   .WIN_BYTES (WIN_BYTES),
   .NUM_BANKS (NUM_BANKS),
   .BASE_ADDR (BASE_ADDR),
   .OPEN_KEY  (OPEN_KEY),
   .CLOSE_KEY (CLOSE_KEY)
) u_wlk_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_rdata  (bus_rdata),
   .mode_wr_en (mode_wr_en),
   .lock_q     (lock_q)
);

// File: tb/tb_keyed_wlock.sv
module tb_keyed_wlock;

   localparam int NB = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [11:0]   addr = '0;
   logic [31:0]   wdata = '0;
   logic          wr = 1'b0;
   logic          rd = 1'b0;
   logic [31:0]   rdata;
   logic [NB-1:0] men;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   bit exp_lock = 1'b0;
   bit rd_seen = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   keyed_wlock dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (addr),
      .bus_wdata  (wdata),
      .bus_wr     (wr),
      .bus_rd     (rd),
      .bus_rdata  (rdata),
      .mode_wr_en (men)
   );

   always #4 clk = ~clk;

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   function automatic bit is_lock(logic [11:0] a);
      return (a[11:3] == 9'h011) && (a[2] == 1'b0);
   endfunction

   function automatic logic [31:0] rd_model(logic [11:0] a, bit st);
      return is_lock(a) ? {st, 31'd0} : 32'd0;
   endfunction

   function automatic bit next_lock(logic [11:0] a, logic [31:0] d, bit st);
      if (!is_lock(a)) return st;
      if (d[15:0] == 16'hD42F) return 1'b1;
      if (d[15:0] == 16'h0000) return 1'b0;
      return st;
   endfunction

   // Monitor: pops the scoreboard one cycle after each read strobe
   always @(posedge clk) rd_seen <= rd;

   always @(negedge clk) begin
      if (rd_seen && rst_n) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R9 unexpected read data", rdata, 32'd0);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(rdata == e, t, rdata, e);
         end
      end
   end

   // Checks the one-cycle enable delay after a write strobe (R6)
   task automatic after_write(bit old_st, bit new_st);
      @(negedge clk);
      wr = 1'b0;
      rd = 1'b0;
      check(men == {NB{old_st}}, "R6 enable one cycle after write", 32'(men), 32'({NB{old_st}}));
      @(negedge clk);
      check(men == {NB{new_st}}, "R6 enable two cycles after write", 32'(men), 32'({NB{new_st}}));
   endtask

   task automatic bus_write(logic [11:0] a, logic [31:0] d);
      bit old_st;
      old_st   = exp_lock;
      exp_lock = next_lock(a, d, exp_lock);
      addr  = a;
      wdata = d;
      wr    = 1'b1;
      after_write(old_st, exp_lock);
   endtask

   task automatic bus_read(logic [11:0] a, string tag);
      addr = a;
      rd   = 1'b1;
      exp_q.push_back(rd_model(a, exp_lock));
      tag_q.push_back(tag);
      @(negedge clk);
      rd = 1'b0;
   endtask

   // Read and write on the same edge (R8)
   task automatic bus_both(logic [11:0] a, logic [31:0] d, string tag);
      bit old_st;
      old_st = exp_lock;
      exp_q.push_back(rd_model(a, old_st));
      tag_q.push_back(tag);
      exp_lock = next_lock(a, d, exp_lock);
      addr  = a;
      wdata = d;
      wr    = 1'b1;
      rd    = 1'b1;
      after_write(old_st, exp_lock);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(men == '0, "R1 enables after reset", 32'(men), 32'd0);
      check(rdata == '0, "R1 read data after reset", rdata, 32'd0);
      bus_read(12'h088, "R1 lock word after reset");

      bus_write(12'h088, 32'h0000_1234);
      bus_read(12'h088, "R4 other code while shut");
      bus_write(12'h088, 32'h0000_0000);
      bus_read(12'h088, "R3 zero while shut");

      bus_write(12'h088, 32'hFFFF_D42F);
      bus_read(12'h088, "R2 open with upper bits set, R5 code hidden");
      bus_write(12'h088, 32'h0000_D42E);
      bus_read(12'h088, "R4 other code while open");
      bus_write(12'h088, 32'h0000_D42F);
      bus_read(12'h088, "R2 code while already open");

      bus_write(12'h08C, 32'h0000_0000);
      bus_read(12'h08C, "R7 second word reads zero");
      bus_write(12'h090, 32'h0000_0000);
      bus_read(12'h090, "R7 outside window reads zero");
      bus_read(12'h000, "R7 low address reads zero");
      bus_read(12'h088, "R7 guard still open");

      // R9: read data holds with no read strobe
      repeat (3) @(negedge clk);
      check(rdata == 32'h8000_0000, "R9 read data held", rdata, 32'h8000_0000);

      bus_write(12'h08B, 32'h1234_0000);
      bus_read(12'h089, "R3 close via byte offset 3");

      bus_both(12'h088, 32'h0000_D42F, "R8 read with open write sees old state");
      bus_read(12'h088, "R8 state after open");
      bus_both(12'h088, 32'h0000_0000, "R8 read with close write sees old state");
      bus_read(12'h088, "R8 state after close");

      repeat (2) @(negedge clk);
      if (exp_q.size() != 0)
         check(1'b0, "R9 outstanding reads", 32'(exp_q.size()), 32'd0);

      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule